// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 1024-bit serial EEPROM seen from its three-wire host interface. The host drives a chip select, a serial clock and a data input, and the block answers on a serial data output that comes with its own output enable, so that a pad can make it high-impedance. A width input chooses how the array is seen: either 64 words of 16 bits or 128 bytes of 8 bits. The serial clock and data are taken into the system clock domain through synchronizer flops, and every action happens on an edge that is detected there.

Each command opens with a start bit. An opcode and an address follow, and a data field comes after them when the command writes a value. Reads stream data out MSB first, and the address keeps advancing for as long as the host keeps clocking. Erase and write operations on one location or on the whole array run on their own for a fixed number of system clock cycles. While one of them runs, the host can raise chip select and see busy or ready on the data line. Every write-type operation is blocked until the host has set a write-enable latch, and that latch is clear after reset.

Top module: `sernvm_slave`

## Requirements
- R1: A frame starts at the first 1 sampled on a serial clock rising edge while chip select is high, and zeros before it are ignored. The next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended group.
- R2: In the extended group, the two most significant address-field bits choose the operation: 11 sets the write-enable latch, 00 clears it, 10 erases every location, 01 writes the data field to every location.
- R3: With wide_i=1 the address field is 6 bits and a data field is 16 bits. With wide_i=0 the address field is 7 bits and a data field is 8 bits. Byte address 2k maps to bits 15:8 of word k, and byte address 2k+1 maps to bits 7:0.
- R4: sdo_oe_o is low after reset and whenever chip select is low. It is high only while read data or the busy/ready status is being driven.
- R5: After the last address bit of a read, sdo_o drives a 0. At each later rising edge it drives the next data bit, MSB first. Words follow without a gap, and the address wraps from the last location to location 0.
- R6: A complete write-type frame starts its operation when chip select falls. While chip select is high afterwards, sdo_oe_o=1 and sdo_o is 0 while the operation runs and 1 once it has finished. An operation lasts BUSY_CYCLES system clock cycles, or one cycle per word if that is more.
- R7: If a 1 is sampled on a rising edge while status is shown, the output goes back to high-impedance at the next falling edge of the serial clock.
- R8: An erase leaves a location reading all ones. A write leaves it reading the data field, and the bulk forms act on every location.
- R9: The write-enable latch is cleared by reset. While it is clear, write-type frames change no location and no status is shown.
- R10: Frames sent while an operation runs are ignored, and a read sent during that time drives no data.
- R11: Chip select going low discards a partly received frame, and the next start bit opens a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high-impedance |

## Verification
Some properties are checked by assertions on every cycle: the output enable drops once chip select has been low for a cycle, status is released only on a serial clock falling edge, and no operation is launched and no read is streamed while the array is busy. Other behaviour can only be shown by the bench's scenarios against its reference memory. This covers how commands are framed in both widths, how bytes map onto words, the read streams with wrap-around, the gating by the write-enable latch, frame abort, and the timing of busy and ready.

// File: rtl/sernvm_pkg.sv
package sernvm_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    JOB_ERASE,
    JOB_WRITE,
    JOB_ERAL,
    JOB_WRAL
  } job_e;

  typedef enum logic [2:0] {
    FR_HUNT,
    FR_OPC,
    FR_ADDR,
    FR_DATA,
    FR_READ,
    FR_HOLD
  } frame_e;

endpackage

// File: rtl/sernvm_sync.sv
module sernvm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_a,
  input  logic sk_a,
  input  logic di_a,
  output logic cs_q,
  output logic di_q,
  output logic sk_rise,
  output logic sk_fall,
  output logic cs_fall
);
  logic [2:0] pipe [STAGES];
  logic       sk_d;
  logic       cs_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= {cs_a, sk_a, di_a};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_d <= 1'b0;
      cs_d <= 1'b0;
    end else begin
      sk_d <= pipe[STAGES-1][1];
      cs_d <= pipe[STAGES-1][2];
    end
  end

  assign cs_q    = pipe[STAGES-1][2];
  assign di_q    = pipe[STAGES-1][0];
  assign sk_rise = pipe[STAGES-1][1] & ~sk_d;
  assign sk_fall = ~pipe[STAGES-1][1] & sk_d;
  assign cs_fall = ~pipe[STAGES-1][2] & cs_d;

endmodule

// File: rtl/sernvm_store.sv
module sernvm_store
  import sernvm_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WIDX_W      = 6,
  parameter int NADDR_W     = 7,
  parameter int BUSY_CYCLES = 400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  job_e               job,
  input  logic [NADDR_W-1:0] jaddr,
  input  logic [WORD_W-1:0]  jdata,
  input  logic               wide,
  input  logic [WIDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0]  rd_q,
  output logic               busy
);
  localparam int HALF_W = WORD_W / 2;
  localparam int WORDS  = 1 << WIDX_W;
  localparam int EFF    = (BUSY_CYCLES > WORDS) ? BUSY_CYCLES : WORDS;
  localparam int TW     = $clog2(EFF + 1);

  logic [HALF_W-1:0]  hi_mem [WORDS];
  logic [HALF_W-1:0]  lo_mem [WORDS];
  logic [HALF_W-1:0]  q_hi, q_lo;
  logic [TW-1:0]      tmr;
  logic [WIDX_W:0]    walk;
  job_e               cjob;
  logic [NADDR_W-1:0] caddr;
  logic [WORD_W-1:0]  cdata;
  logic               cwide;

  logic               bulk, wr_act, we_hi, we_lo;
  logic [WIDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0]  wval;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      tmr   <= '0;
      walk  <= '0;
      cjob  <= JOB_ERASE;
      caddr <= '0;
      cdata <= '0;
      cwide <= 1'b0;
    end else if (launch && !busy) begin
      busy  <= 1'b1;
      tmr   <= TW'(EFF - 1);
      walk  <= '0;
      cjob  <= job;
      caddr <= jaddr;
      cdata <= jdata;
      cwide <= wide;
    end else if (busy) begin
      if (walk < (WIDX_W+1)'(WORDS)) walk <= walk + 1'b1;
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
    end
  end

  always_comb begin
    bulk   = (cjob == JOB_ERAL) || (cjob == JOB_WRAL);
    wr_act = busy && (bulk ? (walk < (WIDX_W+1)'(WORDS)) : (walk == '0));
    if (bulk)       wr_idx = walk[WIDX_W-1:0];
    else if (cwide) wr_idx = caddr[WIDX_W-1:0];
    else            wr_idx = caddr[NADDR_W-1:1];
    if ((cjob == JOB_ERASE) || (cjob == JOB_ERAL)) wval = '1;
    else if (cwide)                                wval = cdata;
    else                                           wval = {cdata[HALF_W-1:0], cdata[HALF_W-1:0]};
    we_hi = wr_act && (bulk || cwide || !caddr[0]);
    we_lo = wr_act && (bulk || cwide ||  caddr[0]);
  end

  always_ff @(posedge clk) begin
    if (we_hi) hi_mem[wr_idx] <= wval[WORD_W-1:HALF_W];
    q_hi <= hi_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (we_lo) lo_mem[wr_idx] <= wval[HALF_W-1:0];
    q_lo <= lo_mem[rd_idx];
  end

  assign rd_q = {q_hi, q_lo};

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch); // R10
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (we_hi || we_lo) |-> (busy && tmr != '0 || bulk)); // R8

endmodule

// File: rtl/sernvm_frame.sv
module sernvm_frame
  import sernvm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WIDX_W  = 6,
  parameter int NADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_q,
  input  logic               di_q,
  input  logic               sk_rise,
  input  logic               sk_fall,
  input  logic               cs_fall,
  input  logic               wide,
  input  logic               busy,
  input  logic [WORD_W-1:0]  rd_q,
  output logic [WIDX_W-1:0]  rd_idx,
  output logic               launch,
  output job_e               job,
  output logic [NADDR_W-1:0] jaddr,
  output logic [WORD_W-1:0]  jdata,
  output logic               sdo,
  output logic               oe
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  frame_e             state;
  opc_e               opc;
  logic [CNT_W-1:0]   cnt, aw_last, dw_last, rd_cnt;
  logic [NADDR_W-1:0] addr_sh, addr_n, addr_fix, rd_addr, rd_next;
  logic [WORD_W-1:0]  data_sh, data_n, rd_sh, word_sel;
  logic [HALF_W-1:0]  half_sel;
  logic [1:0]         ext;
  logic               wen, armed, stat_flag, rel_pend, rd_do;

  always_comb begin
    aw_last  = wide ? CNT_W'(NADDR_W - 2) : CNT_W'(NADDR_W - 1);
    dw_last  = wide ? CNT_W'(WORD_W - 1)  : CNT_W'(HALF_W - 1);
    addr_n   = {addr_sh[NADDR_W-2:0], di_q};
    addr_fix = wide ? {1'b0, addr_n[NADDR_W-2:0]} : addr_n;
    ext      = wide ? addr_n[NADDR_W-2 -: 2] : addr_n[NADDR_W-1 -: 2];
    data_n   = {data_sh[WORD_W-2:0], di_q};
    rd_idx   = wide ? rd_addr[WIDX_W-1:0] : rd_addr[NADDR_W-1:1];
    rd_next  = wide ? {1'b0, rd_addr[WIDX_W-1:0] + 1'b1} : rd_addr + 1'b1;
    half_sel = rd_addr[0] ? rd_q[HALF_W-1:0] : rd_q[WORD_W-1:HALF_W];
    word_sel = wide ? rd_q : {half_sel, {HALF_W{1'b0}}};
  end

  assign jaddr = addr_sh;
  assign jdata = data_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FR_HUNT;
      opc       <= OP_EXT;
      cnt       <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      wen       <= 1'b0;
      armed     <= 1'b0;
      job       <= JOB_ERASE;
      stat_flag <= 1'b0;
      rel_pend  <= 1'b0;
      rd_addr   <= '0;
      rd_cnt    <= '0;
      rd_sh     <= '0;
      rd_do     <= 1'b0;
      launch    <= 1'b0;
      sdo       <= 1'b0;
      oe        <= 1'b0;
    end else begin
      launch <= 1'b0;

      if (cs_q && state == FR_READ) begin
        oe  <= 1'b1;
        sdo <= rd_do;
      end else if (cs_q && stat_flag) begin
        oe  <= 1'b1;
        sdo <= ~busy;
      end else begin
        oe  <= 1'b0;
        sdo <= 1'b0;
      end

      if (!cs_q) begin
        state    <= FR_HUNT;
        cnt      <= '0;
        rel_pend <= 1'b0;
        armed    <= 1'b0;
        if (cs_fall && armed && wen && !busy) begin
          launch    <= 1'b1;
          stat_flag <= 1'b1;
        end
      end else begin
        if (sk_rise && di_q && stat_flag && state != FR_READ) rel_pend <= 1'b1;
        if (sk_fall && rel_pend) begin
          stat_flag <= 1'b0;
          rel_pend  <= 1'b0;
        end
        if (sk_rise && !busy) begin
          case (state)
            FR_HUNT: begin
              if (di_q) begin
                state <= FR_OPC;
                cnt   <= '0;
              end
            end
            FR_OPC: begin
              opc <= opc_e'({opc[0], di_q});
              if (cnt == CNT_W'(1)) begin
                state <= FR_ADDR;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            FR_ADDR: begin
              addr_sh <= addr_fix;
              if (cnt == aw_last) begin
                cnt <= '0;
                case (opc)
                  OP_READ: begin
                    state   <= FR_READ;
                    rd_addr <= addr_fix;
                    rd_cnt  <= '0;
                    rd_do   <= 1'b0;
                  end
                  OP_WRITE: begin
                    state <= FR_DATA;
                    job   <= JOB_WRITE;
                  end
                  OP_ERASE: begin
                    state <= FR_HOLD;
                    job   <= JOB_ERASE;
                    armed <= 1'b1;
                  end
                  default: begin
                    case (ext)
                      2'b11: begin wen <= 1'b1; state <= FR_HOLD; end
                      2'b00: begin wen <= 1'b0; state <= FR_HOLD; end
                      2'b10: begin job <= JOB_ERAL; armed <= 1'b1; state <= FR_HOLD; end
                      default: begin job <= JOB_WRAL; state <= FR_DATA; end
                    endcase
                  end
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            FR_DATA: begin
              data_sh <= data_n;
              if (cnt == dw_last) begin
                state <= FR_HOLD;
                armed <= 1'b1;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            FR_READ: begin
              if (rd_cnt == '0) begin
                rd_do   <= word_sel[WORD_W-1];
                rd_sh   <= word_sel << 1;
                rd_addr <= rd_next;
              end else begin
                rd_do <= rd_sh[WORD_W-1];
                rd_sh <= rd_sh << 1;
              end
              rd_cnt <= (rd_cnt == dw_last) ? '0 : rd_cnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_STATUS_DROP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_flag) |-> $past(sk_fall)); // R7
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == FR_READ) |-> !busy); // R10

endmodule

// File: rtl/sernvm_slave.sv
module sernvm_slave
  import sernvm_pkg::*;
#(
  parameter int ARRAY_BITS  = 1024,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic wide_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int WORDS   = ARRAY_BITS / WORD_W;
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int NADDR_W = WIDX_W + 1;

  logic               cs_q, di_q, sk_rise, sk_fall, cs_fall;
  logic               launch, busy;
  job_e               job;
  logic [NADDR_W-1:0] jaddr;
  logic [WORD_W-1:0]  jdata, rd_q;
  logic [WIDX_W-1:0]  rd_idx;

  sernvm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_a(cs_i), .sk_a(sclk_i), .di_a(sdi_i),
    .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_fall(cs_fall)
  );

  sernvm_frame #(.WORD_W(WORD_W), .WIDX_W(WIDX_W), .NADDR_W(NADDR_W)) u_frame (
    .clk(clk), .rst(rst), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise),
    .sk_fall(sk_fall), .cs_fall(cs_fall), .wide(wide_i), .busy(busy),
    .rd_q(rd_q), .rd_idx(rd_idx), .launch(launch), .job(job),
    .jaddr(jaddr), .jdata(jdata), .sdo(sdo_o), .oe(sdo_oe_o)
  );

  sernvm_store #(.WORD_W(WORD_W), .WIDX_W(WIDX_W), .NADDR_W(NADDR_W),
                 .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst(rst), .launch(launch), .job(job), .jaddr(jaddr),
    .jdata(jdata), .wide(wide_i), .rd_idx(rd_idx), .rd_q(rd_q), .busy(busy)
  );

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> !sdo_oe_o); // R4

endmodule

// File: tb/sernvm_slave_bench.sv
module sernvm_slave_bench;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, wide = 1'b1;
  logic sdo, sdo_oe;
  int   compared = 0;
  int   mismatched = 0;
  logic [15:0] ref_mem [64];

  always #4 clk = ~clk;

  sernvm_slave u_sernvm_slave (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .wide_i(wide), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic d, output logic o, output logic e);
    sdi = d;
    sclk = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    o = sdo;
    e = sdo_oe;
    sclk = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic tick(input logic d);
    logic o, e;
    bitx(d, o, e);
  endtask

  task automatic cs_up();
    sclk = 1'b0;
    cs = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic cs_dn();
    sclk = 1'b0;
    repeat (4) @(posedge clk);
    cs = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic header(input logic [1:0] op, input int addr);
    tick(1'b1);
    tick(op[1]);
    tick(op[0]);
    for (int i = (wide ? 5 : 6); i >= 0; i--) tick(addr[i]);
  endtask

  task automatic cmd(input logic [1:0] op, input int addr, input logic [15:0] data, input bit has_data);
    cs_up();
    header(op, addr);
    if (has_data) for (int i = (wide ? 15 : 7); i >= 0; i--) tick(data[i]);
    cs_dn();
  endtask

  function automatic logic [15:0] exp_unit(input int a);
    if (wide) return ref_mem[a];
    return a[0] ? {8'h00, ref_mem[a >> 1][7:0]} : {8'h00, ref_mem[a >> 1][15:8]};
  endfunction

  task automatic rd(input int addr, input int nwords, input int lead0, input string req);
    logic o, e;
    logic [15:0] got;
    int a = addr;
    cs_up();
    for (int i = 0; i < lead0; i++) tick(1'b0);
    header(2'b10, addr);
    bitx(1'b0, o, e);
    chk(e == 1'b1 && o == 1'b0, "R5 leading zero", {e, o}, 2'b10);
    for (int w = 0; w < nwords; w++) begin
      got = '0;
      for (int b = 0; b < (wide ? 16 : 8); b++) begin
        bitx(1'b0, o, e);
        got = {got[14:0], o};
      end
      chk(got == exp_unit(a), req, got, exp_unit(a));
      a = wide ? (a + 1) % 64 : (a + 1) % 128;
    end
    cs_dn();
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R4 released after read", sdo_oe, 0);
  endtask

  task automatic wait_ready(input string req);
    logic o, e;
    cs_up();
    @(negedge clk);
    chk(sdo_oe == 1'b1 && sdo == 1'b0, "R6 busy status", {sdo_oe, sdo}, 2'b10);
    repeat (BUSY + 20) @(posedge clk);
    @(negedge clk);
    chk(sdo_oe == 1'b1 && sdo == 1'b1, req, {sdo_oe, sdo}, 2'b11);
    tick(1'b1);
    bitx(1'b0, o, e);
    chk(e == 1'b0, "R7 dummy one releases", e, 0);
    cs_dn();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R4 reset state", sdo_oe, 0);

    // R9: latch clear after reset, write is dropped and no status appears
    cmd(2'b01, 5, 16'h1234, 1);
    cs_up();
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R9 locked write shows no status", sdo_oe, 0);
    cs_dn();

    // R2: enable then erase-all
    cmd(2'b00, 6'b110000, 16'h0, 0);
    cmd(2'b00, 6'b100000, 16'h0, 0);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    wait_ready("R6 ready after erase-all");
    rd(5, 1, 0, "R8 erased word reads ones");
    rd(9, 1, 3, "R1 leading zeros ignored");

    // R8: single writes, R5: sequential read with wrap
    cmd(2'b01, 5, 16'hA5C3, 1);
    ref_mem[5] = 16'hA5C3;
    wait_ready("R6 ready after write");
    rd(5, 1, 0, "R8 written word");
    cmd(2'b01, 63, 16'h0F0F, 1);
    ref_mem[63] = 16'h0F0F;
    wait_ready("R6 ready after write 63");
    rd(63, 3, 0, "R5 sequential wrap wide");

    // R3: byte view
    wide = 1'b0;
    rd(10, 2, 0, "R3 byte mapping");
    cmd(2'b01, 11, 16'h003C, 1);
    ref_mem[5][7:0] = 8'h3C;
    wait_ready("R6 ready after byte write");
    rd(127, 2, 0, "R5 sequential wrap narrow");
    wide = 1'b1;
    rd(5, 1, 0, "R3 byte write lands in low half");

    // R9: disable then try to write
    cmd(2'b00, 6'b000000, 16'h0, 0);
    cmd(2'b01, 5, 16'h0000, 1);
    cs_up();
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R9 disabled write shows no status", sdo_oe, 0);
    cs_dn();
    rd(5, 1, 0, "R9 disabled write left word");

    // R10: read while busy is ignored
    cmd(2'b00, 6'b110000, 16'h0, 0);
    cmd(2'b11, 63, 16'h0, 0);
    ref_mem[63] = 16'hFFFF;
    begin
      logic o, e;
      cs_up();
      bitx(1'b1, o, e);
      chk(e == 1'b1 && o == 1'b0, "R6 busy during erase", {e, o}, 2'b10);
      tick(1'b1);
      tick(1'b0);
      for (int i = 5; i >= 0; i--) tick(i[0] ^ i[2]);
      bitx(1'b0, o, e);
      chk(e == 1'b0, "R10 read while busy drives nothing", e, 0);
      cs_dn();
    end
    repeat (BUSY + 40) @(posedge clk);
    rd(63, 1, 0, "R8 erase single word");

    // R11: abort a partial write
    cs_up();
    tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0);
    cs_dn();
    rd(5, 1, 0, "R11 aborted frame left word");

    // R2: write-all in both widths
    cmd(2'b00, 6'b010000, 16'h1234, 1);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'h1234;
    wait_ready("R6 ready after write-all");
    rd(0, 1, 0, "R2 write-all first word");
    rd(63, 1, 0, "R2 write-all last word");
    wide = 1'b0;
    cmd(2'b00, 7'b0100000, 16'h005A, 1);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'h5A5A;
    wait_ready("R6 ready after narrow write-all");
    wide = 1'b1;
    rd(7, 1, 0, "R3 narrow write-all fills both halves");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule